// File: doc/BRIEF.md
# Quant-Based Effect Dispatch Scheduler

This block decides which queued effect is handed to which processing entity, and when. Each handoff is a wave. A wave is atomic: the block names one entity and one data word, then waits for the wave-done handshake before it dispatches anything else. Waves are grouped into quants. Effects that a wave produces with no delay join the quant that is running and may start further waves in it. A quant ends when its current queue is empty. The next quant then begins, provided some work is pending.

Three kinds of work wait for a later quant:
- External effects that arrive while a quant runs.
- Effects that would push an entity past its per-quant invocation budget.
- Internal effects that carry a delay of one or more quants.

At each boundary the block moves this work into the current queue in a fixed order. It then raises a single-cycle quant-start pulse. Delayed effects count down one step per boundary. A quant may therefore pass with no dispatch while an effect is still counting down.

An effect is an entity number plus a data word. The computation itself lives outside the block. If a queue is full, the incoming effect is dropped and an overflow pulse is raised. Effects already queued are never overwritten.

Top module: `quant_sched`

## Requirements
- R1: While reset is high, `disp_valid`, `quant_start` and `overflow` are all low. After reset the block is idle and every queue is empty.
- R2: Once `disp_valid` rises, it stays high with `disp_entity` and `disp_data` unchanged until a cycle in which `wave_done` is high. In the following cycle `disp_valid` is low. Only one wave is outstanding at any time.
- R3: An internal effect with `int_delay` = 0 is dispatched in the same quant. It comes after every effect already in the current queue, in first-in first-out order.
- R4: An external effect that arrives after the block has started its boundary transfer is not dispatched in the quant that follows that transfer. It is dispatched in the quant after it. At a boundary, the postponed work (budget deferrals and delay-1 effects) is moved into the new quant first, then external effects in arrival order, then expired delayed effects.
- R5: Each entity is dispatched at most LIMIT times per quant. When the head of the current queue names an entity whose budget is used up, that effect is moved to the next quant, keeping its relative order.
- R6: All per-entity invocation counts return to zero when a new quant starts. An entity that used up its budget in one quant can be dispatched again in the next.
- R7: An internal effect with `int_delay` = d ≥ 1 is dispatched in the quant that starts d boundaries after the one in which it was produced.
- R8: A quant ends when its current queue is empty. If any effect is pending, `quant_start` pulses high for exactly one cycle when the new quant begins, and no wave is outstanding in that cycle. If nothing is pending, the block stays idle and issues no `quant_start`.
- R9: An effect whose target queue is full is dropped. `overflow` goes high for one cycle, in the cycle after the effect was presented. Effects already queued are still dispatched unchanged.
- R10: `int_valid` and `wave_done` are ignored while no wave is outstanding: they cause no dispatch and no quant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_valid | input | 1 | External effect present this cycle |
| ext_entity | input | ENT_W | Target entity of the external effect |
| ext_data | input | DATA_W | Data of the external effect |
| int_valid | input | 1 | Internal effect present this cycle (taken only during a wave) |
| int_entity | input | ENT_W | Target entity of the internal effect |
| int_data | input | DATA_W | Data of the internal effect |
| int_delay | input | DLY_W | Number of quants before the internal effect becomes eligible |
| disp_valid | output | 1 | A wave is outstanding |
| disp_entity | output | ENT_W | Entity that processes the current wave |
| disp_data | output | DATA_W | Data of the current wave |
| wave_done | input | 1 | The current wave has finished |
| quant_start | output | 1 | One-cycle pulse when a new quant begins |
| overflow | output | 1 | One-cycle pulse when an effect was dropped |

## Verification
All outputs are registered, and each check is timed to the edge that updates it:
- `overflow` answers the edge after the offending input, so the bench checks it at the next falling edge and again one cycle later to prove it is a pulse.
- `disp_valid` falls on the edge that samples `wave_done`. It rises one cycle after the scheduler picks the queue head, which is at the earliest the cycle after `quant_start`.

Rather than counting exact cycles through boundary transfers, the bench labels every dispatch with the number of `quant_start` pulses seen so far. It then compares the full sequence of entity, data and quant label with values worked out from the delay counts, the budget and the queue order.

// File: rtl/quant_sched_pkg.sv
package quant_sched_pkg;

  // Scheduler phases: pick from the current queue, wait on a wave,
  // or move pending work across a quant boundary.
  typedef enum logic [1:0] {
    QS_RUN  = 2'd0,
    QS_WAVE = 2'd1,
    QS_XFER = 2'd2
  } qs_state_e;

endpackage

// File: rtl/qs_fifo.sv
module qs_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (cnt != '0);
  assign dout    = mem[rd_ptr];
  assign count   = cnt;

  // storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/qs_slots.sv
module qs_slots #(
  parameter int W     = 10,
  parameter int SLOTS = 4,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins,
  input  logic [DLY_W-1:0] ins_dly,
  input  logic [W-1:0]     ins_eff,
  input  logic             tick,
  input  logic             take,
  output logic             full,
  output logic             busy,
  output logic             ready,
  output logic [W-1:0]     ready_eff
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] vld;
  logic [DLY_W-1:0] cnt [SLOTS];
  logic [W-1:0]     eff [SLOTS];
  logic [IW-1:0]    free_idx, rdy_idx;
  logic             has_free, has_rdy;

  // lowest free slot and lowest expired slot
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    has_rdy  = 1'b0;
    rdy_idx  = '0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
      if (vld[i] && cnt[i] == '0) begin
        has_rdy = 1'b1;
        rdy_idx = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic             v;
    logic [DLY_W-1:0] c;
    logic [W-1:0]     e;

    always_ff @(posedge clk) begin
      if (rst) begin
        v <= 1'b0;
        c <= '0;
        e <= '0;
      end else if (take && has_rdy && rdy_idx == IW'(g)) begin
        v <= 1'b0;
      end else if (ins && has_free && free_idx == IW'(g)) begin
        v <= 1'b1;
        c <= ins_dly;
        e <= ins_eff;
      end else if (tick && v && c != '0) begin
        c <= c - DLY_W'(1);
      end
    end

    assign vld[g] = v;
    assign cnt[g] = c;
    assign eff[g] = e;
  end

  assign full      = &vld;
  assign busy      = |vld;
  assign ready     = has_rdy;
  assign ready_eff = eff[rdy_idx];
endmodule

// File: rtl/qs_budget.sv
module qs_budget #(
  parameter int ENT_W = 2,
  parameter int LIMIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [ENT_W-1:0] ent,
  output logic             under
);
  localparam int NE = 1 << ENT_W;
  localparam int BW = $clog2(LIMIT+1);

  logic [BW-1:0] cnts [NE];

  for (genvar g = 0; g < NE; g++) begin : g_ent
    logic [BW-1:0] c;
    always_ff @(posedge clk) begin
      if (rst || clr)
        c <= '0;
      else if (inc && ent == ENT_W'(g) && c != BW'(LIMIT))
        c <= c + BW'(1);
    end
    assign cnts[g] = c;
  end

  assign under = (cnts[ent] < BW'(LIMIT));
endmodule

// File: rtl/quant_sched.sv
module quant_sched
  import quant_sched_pkg::*;
#(
  parameter int ENT_W  = 2,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int SLOTS  = 4,
  parameter int DLY_W  = 3,
  parameter int LIMIT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_valid,
  input  logic [ENT_W-1:0]  ext_entity,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              int_valid,
  input  logic [ENT_W-1:0]  int_entity,
  input  logic [DATA_W-1:0] int_data,
  input  logic [DLY_W-1:0]  int_delay,
  output logic              disp_valid,
  output logic [ENT_W-1:0]  disp_entity,
  output logic [DATA_W-1:0] disp_data,
  input  logic              wave_done,
  output logic              quant_start,
  output logic              overflow
);
  localparam int EFF_W = ENT_W + DATA_W;
  localparam int CW    = $clog2(DEPTH+1);

  qs_state_e st;

  logic [EFF_W-1:0] int_eff, cur_head, next_head, ext_head, slot_eff, cur_din, next_din;
  logic [CW-1:0]    cur_cnt, next_cnt, ext_cnt, ext_left;
  logic cur_full, next_full, ext_full, slot_full, slot_busy, slot_ready;
  logic cur_empty, next_empty, ext_empty, under;
  logic int_acc, int_to_cur, int_to_next, int_to_slot;
  logic run_dispatch, run_defer, run_end, pending;
  logic xf_next, xf_ext, xf_slot, xf_done, ovf_c;

  assign int_eff    = {int_entity, int_data};
  assign cur_empty  = (cur_cnt == '0);
  assign next_empty = (next_cnt == '0);
  assign ext_empty  = (ext_cnt == '0);

  // internal effects are taken only while a wave is outstanding
  assign int_acc     = (st == QS_WAVE) && int_valid;
  assign int_to_cur  = int_acc && (int_delay == '0);
  assign int_to_next = int_acc && (int_delay == DLY_W'(1));
  assign int_to_slot = int_acc && (int_delay > DLY_W'(1));

  // choosing from the current queue
  assign pending      = !next_empty || !ext_empty || slot_busy;
  assign run_dispatch = (st == QS_RUN) && !cur_empty && under;
  assign run_defer    = (st == QS_RUN) && !cur_empty && !under;
  assign run_end      = (st == QS_RUN) && cur_empty && pending;

  // boundary transfer: postponed first, then external snapshot, then expired delays
  assign xf_next = (st == QS_XFER) && !cur_full && !next_empty;
  assign xf_ext  = (st == QS_XFER) && !cur_full && next_empty &&
                   (ext_left != '0) && !ext_empty;
  assign xf_slot = (st == QS_XFER) && !cur_full && !xf_next && !xf_ext && slot_ready;
  assign xf_done = (st == QS_XFER) && !(xf_next || xf_ext || xf_slot);

  always_comb begin
    if (xf_next)      cur_din = next_head;
    else if (xf_ext)  cur_din = ext_head;
    else if (xf_slot) cur_din = slot_eff;
    else              cur_din = int_eff;
  end
  assign next_din = run_defer ? cur_head : int_eff;

  assign ovf_c = (ext_valid && ext_full) ||
                 (int_to_cur && cur_full) ||
                 (int_to_next && next_full) ||
                 (run_defer && next_full) ||
                 (int_to_slot && slot_full);

  qs_fifo #(.W(EFF_W), .DEPTH(DEPTH)) u_cur (
    .clk(clk), .rst(rst),
    .push(int_to_cur || xf_next || xf_ext || xf_slot), .din(cur_din),
    .pop(run_dispatch || run_defer), .dout(cur_head),
    .full(cur_full), .count(cur_cnt)
  );

  qs_fifo #(.W(EFF_W), .DEPTH(DEPTH)) u_next (
    .clk(clk), .rst(rst),
    .push(int_to_next || run_defer), .din(next_din),
    .pop(xf_next), .dout(next_head),
    .full(next_full), .count(next_cnt)
  );

  qs_fifo #(.W(EFF_W), .DEPTH(DEPTH)) u_ext (
    .clk(clk), .rst(rst),
    .push(ext_valid), .din({ext_entity, ext_data}),
    .pop(xf_ext), .dout(ext_head),
    .full(ext_full), .count(ext_cnt)
  );

  qs_slots #(.W(EFF_W), .SLOTS(SLOTS), .DLY_W(DLY_W)) u_slots (
    .clk(clk), .rst(rst),
    .ins(int_to_slot), .ins_dly(int_delay), .ins_eff(int_eff),
    .tick(run_end), .take(xf_slot),
    .full(slot_full), .busy(slot_busy),
    .ready(slot_ready), .ready_eff(slot_eff)
  );

  qs_budget #(.ENT_W(ENT_W), .LIMIT(LIMIT)) u_budget (
    .clk(clk), .rst(rst),
    .clr(run_end), .inc(run_dispatch),
    .ent(cur_head[EFF_W-1 -: ENT_W]), .under(under)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= QS_RUN;
      disp_valid  <= 1'b0;
      disp_entity <= '0;
      disp_data   <= '0;
      quant_start <= 1'b0;
      overflow    <= 1'b0;
      ext_left    <= '0;
    end else begin
      quant_start <= xf_done;
      overflow    <= ovf_c;
      case (st)
        QS_RUN: begin
          if (run_dispatch) begin
            st          <= QS_WAVE;
            disp_valid  <= 1'b1;
            disp_entity <= cur_head[EFF_W-1 -: ENT_W];
            disp_data   <= cur_head[DATA_W-1:0];
          end else if (run_end) begin
            st       <= QS_XFER;
            ext_left <= ext_cnt;
          end
        end
        QS_WAVE: begin
          if (wave_done) begin
            disp_valid <= 1'b0;
            st         <= QS_RUN;
          end
        end
        QS_XFER: begin
          if (xf_ext)  ext_left <= ext_left - CW'(1);
          if (xf_done) st <= QS_RUN;
        end
        default: st <= QS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/quant_sched_chk.sv
module quant_sched_chk #(
  parameter int ENT_W  = 2,
  parameter int DATA_W = 8,
  parameter int LIMIT  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              disp_valid,
  input logic [ENT_W-1:0]  disp_entity,
  input logic [DATA_W-1:0] disp_data,
  input logic              wave_done,
  input logic              quant_start
);
  localparam int NE   = 1 << ENT_W;
  localparam int SW   = $clog2(LIMIT+2);
  localparam int SMAX = LIMIT + 1;

  logic          prev_disp;
  logic          rise;
  logic [SW-1:0] seen [NE];

  assign rise = disp_valid && !prev_disp;

  always_ff @(posedge clk) begin
    if (rst) prev_disp <= 1'b0;
    else     prev_disp <= disp_valid;
  end

  // dispatches per entity since the last quant start
  always_ff @(posedge clk) begin
    for (int i = 0; i < NE; i++) begin
      if (rst || quant_start)
        seen[i] <= '0;
      else if (rise && disp_entity == ENT_W'(i) && seen[i] != SW'(SMAX))
        seen[i] <= seen[i] + SW'(1);
    end
  end

  // R2
  wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid && !wave_done |=> disp_valid && $stable(disp_entity) && $stable(disp_data));

  // R2
  wave_end_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid && wave_done |=> !disp_valid);

  // R8
  quant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    quant_start |=> !quant_start);

  // R8
  quant_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    quant_start |-> !disp_valid);

  // R5
  budget_limit_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> seen[disp_entity] < SW'(LIMIT));
endmodule

bind quant_sched quant_sched_chk #(
  .ENT_W(ENT_W), .DATA_W(DATA_W), .LIMIT(LIMIT)
) u_chk (
  .clk(clk), .rst(rst),
  .disp_valid(disp_valid), .disp_entity(disp_entity), .disp_data(disp_data),
  .wave_done(wave_done), .quant_start(quant_start)
);

// File: tb/tb_quant_sched.sv
`timescale 1ns/1ps
module tb_quant_sched;
  localparam int ENT_W  = 2;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int SLOTS  = 4;
  localparam int DLY_W  = 3;
  localparam int LIMIT  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // stimulus from the main flow (m_) and the wave responder (r_)
  logic              m_ext_v = 1'b0, r_ext_v = 1'b0;
  logic [ENT_W-1:0]  m_ext_e = '0,   r_ext_e = '0;
  logic [DATA_W-1:0] m_ext_d = '0,   r_ext_d = '0;
  logic              m_int_v = 1'b0, r_int_v = 1'b0;
  logic [ENT_W-1:0]  m_int_e = '0,   r_int_e = '0;
  logic [DATA_W-1:0] m_int_d = '0,   r_int_d = '0;
  logic [DLY_W-1:0]  m_int_l = '0,   r_int_l = '0;
  logic              m_wd = 1'b0,    r_wd = 1'b0;

  logic              ext_valid, int_valid, wave_done;
  logic [ENT_W-1:0]  ext_entity, int_entity, disp_entity;
  logic [DATA_W-1:0] ext_data, int_data, disp_data;
  logic [DLY_W-1:0]  int_delay;
  logic              disp_valid, quant_start, overflow;

  assign ext_valid  = m_ext_v | r_ext_v;
  assign ext_entity = r_ext_v ? r_ext_e : m_ext_e;
  assign ext_data   = r_ext_v ? r_ext_d : m_ext_d;
  assign int_valid  = m_int_v | r_int_v;
  assign int_entity = r_int_v ? r_int_e : m_int_e;
  assign int_data   = r_int_v ? r_int_d : m_int_d;
  assign int_delay  = r_int_v ? r_int_l : m_int_l;
  assign wave_done  = m_wd | r_wd;

  quant_sched #(
    .ENT_W(ENT_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .SLOTS(SLOTS), .DLY_W(DLY_W), .LIMIT(LIMIT)
  ) dut (
    .clk(clk), .rst(rst),
    .ext_valid(ext_valid), .ext_entity(ext_entity), .ext_data(ext_data),
    .int_valid(int_valid), .int_entity(int_entity), .int_data(int_data),
    .int_delay(int_delay),
    .disp_valid(disp_valid), .disp_entity(disp_entity), .disp_data(disp_data),
    .wave_done(wave_done), .quant_start(quant_start), .overflow(overflow)
  );

  // monitor and wave responder
  int rec_d [64];
  int rec_e [64];
  int rec_q [64];
  int nrec = 0, qidx = 0, mon_bad = 0, wide = 0, wcnt = 0;
  logic prev_disp = 1'b0, prev_qs = 1'b0, hold = 1'b0;
  logic [DATA_W-1:0] last_d = '0;
  logic [ENT_W-1:0]  last_e = '0;

  always @(negedge clk) begin
    r_wd = 1'b0; r_int_v = 1'b0; r_ext_v = 1'b0;
    if (rst) begin
      prev_disp = 1'b0; prev_qs = 1'b0; wcnt = 0;
    end else begin
      if (quant_start) begin
        qidx++;
        if (prev_qs) wide++;
      end
      prev_qs = quant_start;
      if (disp_valid && !prev_disp && nrec < 64) begin
        rec_d[nrec] = int'(disp_data);
        rec_e[nrec] = int'(disp_entity);
        rec_q[nrec] = qidx;
        nrec++;
      end
      if (disp_valid && prev_disp && (disp_data != last_d || disp_entity != last_e))
        mon_bad++;
      last_d = disp_data; last_e = disp_entity;
      prev_disp = disp_valid;
      if (disp_valid) begin
        if (wcnt >= 2 && !hold) begin
          r_wd = 1'b1;
          wcnt = 0;
          case (disp_data)
            8'd10: begin
              r_int_v = 1'b1; r_int_e = 2'd1; r_int_d = 8'd35; r_int_l = 3'd1;
              r_ext_v = 1'b1; r_ext_e = 2'd2; r_ext_d = 8'd20;
            end
            8'd11: begin
              r_int_v = 1'b1; r_int_e = 2'd3; r_int_d = 8'd30; r_int_l = 3'd0;
            end
            8'd12: begin
              r_int_v = 1'b1; r_int_e = 2'd0; r_int_d = 8'd40; r_int_l = 3'd2;
            end
            default: ;
          endcase
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  int checks = 0, fails = 0;
  logic wd_hit = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rec(input int i, input int d, input int e, input int q, input string req);
    bit ok;
    ok = (i < nrec) && rec_d[i] == d && rec_e[i] == e && rec_q[i] == q;
    checks++;
    if (!ok) begin
      fails++;
      if (i < nrec)
        $display("FAIL %s: dispatch %0d actual data %0d ent %0d quant %0d expected data %0d ent %0d quant %0d",
                 req, i, rec_d[i], rec_e[i], rec_q[i], d, e, q);
      else
        $display("FAIL %s: dispatch %0d actual missing expected data %0d ent %0d quant %0d",
                 req, i, d, e, q);
    end
  endtask

  task automatic push_ext(input int e, input int d);
    m_ext_v = 1'b1;
    m_ext_e = ENT_W'(e);
    m_ext_d = DATA_W'(d);
    @(negedge clk);
    m_ext_v = 1'b0;
  endtask

  task automatic wait_disp();
    while (!disp_valid) @(negedge clk);
  endtask

  task automatic run_all();
    int bq, br, qs;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(disp_valid == 1'b0, "R1 disp_valid", int'(disp_valid), 0);
    check(quant_start == 1'b0, "R1 quant_start", int'(quant_start), 0);
    check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
    rst = 1'b0;

    // R8 idle with empty queues
    repeat (20) @(negedge clk);
    check(qidx == 0, "R8 idle quants", qidx, 0);

    // R10 internal effect and wave_done outside a wave
    m_int_v = 1'b1; m_int_e = 2'd1; m_int_d = 8'd99; m_int_l = 3'd0; m_wd = 1'b1;
    @(negedge clk);
    m_int_v = 1'b0; m_wd = 1'b0;
    repeat (30) @(negedge clk);
    check(nrec == 0, "R10 no dispatch", nrec, 0);
    check(qidx == 0, "R10 no quant", qidx, 0);

    // cascade: delay 0, delay 1, delay 2, external during quant
    bq = qidx; br = nrec;
    hold = 1'b1;
    push_ext(3, 1);
    wait_disp();
    push_ext(0, 10);
    push_ext(1, 11);
    push_ext(2, 12);
    hold = 1'b0;
    repeat (150) @(negedge clk);
    check_rec(br+0, 1, 3, bq+1, "R8 first quant");
    check_rec(br+1, 10, 0, bq+2, "R4 held external");
    check_rec(br+2, 11, 1, bq+2, "R4 held external");
    check_rec(br+3, 12, 2, bq+2, "R4 held external");
    check_rec(br+4, 30, 3, bq+2, "R3 same quant");
    check_rec(br+5, 35, 1, bq+3, "R7 delay one");
    check_rec(br+6, 20, 2, bq+3, "R4 external after postponed");
    check_rec(br+7, 40, 0, bq+4, "R7 delay two");
    check(nrec == br+8, "R8 dispatch count", nrec, br+8);
    check(qidx == bq+4, "R8 quant count", qidx, bq+4);

    // budget and overflow
    bq = qidx; br = nrec;
    hold = 1'b1;
    push_ext(1, 60);
    wait_disp();
    for (int k = 1; k <= 8; k++) push_ext((k-1)%3+1, 60+k);
    check(overflow == 1'b0, "R9 no overflow at capacity", int'(overflow), 0);
    push_ext(3, 69);
    check(overflow == 1'b1, "R9 overflow raised", int'(overflow), 1);
    @(negedge clk);
    check(overflow == 1'b0, "R9 overflow pulse", int'(overflow), 0);
    hold = 1'b0;
    repeat (200) @(negedge clk);
    check_rec(br+0, 60, 1, bq+1, "R5 first quant");
    check_rec(br+1, 61, 1, bq+2, "R6 budget restored");
    check_rec(br+2, 62, 2, bq+2, "R5 within budget");
    check_rec(br+3, 63, 3, bq+2, "R5 within budget");
    check_rec(br+4, 64, 1, bq+2, "R6 budget restored");
    check_rec(br+5, 65, 2, bq+2, "R5 within budget");
    check_rec(br+6, 66, 3, bq+2, "R5 within budget");
    check_rec(br+7, 67, 1, bq+3, "R5 deferred");
    check_rec(br+8, 68, 2, bq+3, "R5 deferred");
    check(nrec == br+9, "R9 dropped effect absent", nrec, br+9);

    // R8 stays idle once drained
    qs = qidx;
    repeat (40) @(negedge clk);
    check(qidx == qs, "R8 idle after drain", qidx, qs);
    check(mon_bad == 0, "R2 wave stable", mon_bad, 0);
    check(wide == 0, "R8 single-cycle quant_start", wide, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) check(1'b0, "watchdog", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule